// File: doc/BRIEF.md
# Ethernet Port Statistics Counter Bank

The bank keeps a set of 64-bit counters for every port of a small switch and updates them from one receive event strobe and one transmit event strobe per port and cycle. A receive event carries the frame length, CRC-error and alignment-error flags, an address class (unicast, multicast, broadcast), a VLAN-tag flag, a pause flag and a drop flag. A transmit event carries the length, a success flag, the class, VLAN and pause flags, a collision outcome code, a deferral flag and a carrier-sense error flag. Received frames are also binned by length into a seven-bin size histogram.

Software reads the counters over a bus as wide as half a counter. A read of a counter's low word returns that word and, in the same clock edge, captures the counter's upper half into one shared high-word register. A later read of that register returns the captured half even if the counter has carried since, so a low read followed by a high read always gives one consistent full count.

The read path is a three-state machine. RD_IDLE means no response is presented. Accepting a low-word read moves to RD_LOW, accepting a high-register read moves to RD_HIGH, and a cycle with no request moves back to RD_IDLE. Every state takes these same three transitions, so reads may be issued back to back.

Top module: `stat_bank`

## Requirements
- R1: A synchronous reset clears every counter, the shared high-word register and the read response, and holds `rd_valid` low.
- R2: A request on `rd_en` gives `rd_valid` high for exactly the next cycle with `rd_data` valid in that cycle. The address is {select, port, index}: the top bit set selects the shared high-word register, otherwise the middle bits pick the port and the low 6 bits the counter. Counter indices: 0 rx good, 1 rx octets, 2 rx unicast, 3 rx multicast, 4 rx broadcast, 5 rx VLAN, 6 rx pause, 7 rx CRC error, 8 rx alignment error, 9 rx undersize, 10 rx fragment, 11 rx oversize, 12 rx jabber, 13 rx drop, 14 to 20 size bins, 21 tx good, 22 tx octets, 23 tx unicast, 24 tx multicast, 25 tx broadcast, 26 tx VLAN, 27 tx pause, 28 single collision, 29 multiple collision, 30 late collision, 31 excessive collision, 32 deferred, 33 carrier-sense error.
- R3: A low-word read loads the same counter's upper half into the shared high-word register; a high-register read returns that value, unchanged by later carries, until the next low-word read.
- R4: A counter incremented in the same cycle as its low-word read returns, in both halves, its value before that increment.
- R5: A receive frame with neither error flag and a length from 64 to MAX_LEN adds 1 to rx good, its length to rx octets, 1 to the class counter (class code 0 unicast, 1 multicast, 2 broadcast, 3 none), and 1 to rx VLAN and rx pause when those flags are set. No other frame touches these counters.
- R6: Each CRC-error flag and alignment-error flag adds 1 to its counter. A frame shorter than 64 counts as undersize without errors and as fragment with an error; a frame longer than MAX_LEN counts as oversize without errors and as jabber with an error.
- R7: Every received frame of length up to MAX_LEN adds 1 to exactly one size bin: up to 64, 65 to 127, 128 to 255, 256 to 511, 512 to 1023, 1024 to 1518, 1519 to MAX_LEN (indices 14 to 20 in that order).
- R8: A transmit event with the success flag adds 1 to tx good, its length to tx octets, 1 to its class counter and to tx VLAN and tx pause when flagged; without the success flag none of these change.
- R9: A transmit event's collision code 1, 2, 3, 4 adds 1 to single, multiple, late, excessive collision respectively (0 and 5 to 7 count nothing); the deferral and carrier-sense flags each add 1 to their counter, whether or not the frame succeeded.
- R10: A receive event with the drop flag adds 1 to rx drop regardless of its length and errors.
- R11: Events on one port change only that port's counters.
- R12: A low-word read of an index from 34 to 63, or of a port number not present, returns zero and loads zero into the high-word register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_vld | input | NUM_PORTS | Receive event strobe per port |
| rx_len | input | NUM_PORTS*LEN_W | Receive frame length per port |
| rx_fcs_err | input | NUM_PORTS | CRC error flag |
| rx_align_err | input | NUM_PORTS | Alignment error flag |
| rx_cls | input | NUM_PORTS*2 | Receive address class code |
| rx_vlan | input | NUM_PORTS | Receive frame carried a VLAN tag |
| rx_pause | input | NUM_PORTS | Receive frame was a pause frame |
| rx_drop | input | NUM_PORTS | Receive frame was dropped |
| tx_vld | input | NUM_PORTS | Transmit event strobe per port |
| tx_len | input | NUM_PORTS*LEN_W | Transmit frame length per port |
| tx_ok | input | NUM_PORTS | Transmit frame succeeded |
| tx_cls | input | NUM_PORTS*2 | Transmit address class code |
| tx_vlan | input | NUM_PORTS | Transmit frame carried a VLAN tag |
| tx_pause | input | NUM_PORTS | Transmit frame was a pause frame |
| tx_col | input | NUM_PORTS*3 | Collision outcome code |
| tx_defer | input | NUM_PORTS | Transmission was deferred |
| tx_crs_err | input | NUM_PORTS | Carrier-sense error |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address {select, port, index} |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | DATA_W | Read response data |

## Verification
On every cycle the assertions check the read handshake (one response cycle per request, none without one), that unmapped low-word reads return zero, and that two high-register reads with no low-word read between them return the same word. The counting rules, the size binning, the port separation, the capture of the upper half across a carry and the pre-increment value on a same-cycle read can only be shown by the bench's scenarios, which compare every response against a behavioural model of all counters.

// File: rtl/stat_pkg.sv
package stat_pkg;

    localparam int IDX_W   = 6;
    localparam int NUM_CNT = 34;

    localparam int C_RX_GOOD  = 0;
    localparam int C_RX_BYTES = 1;
    localparam int C_RX_UC    = 2;
    localparam int C_RX_MC    = 3;
    localparam int C_RX_BC    = 4;
    localparam int C_RX_VLAN  = 5;
    localparam int C_RX_PAUSE = 6;
    localparam int C_RX_FCS   = 7;
    localparam int C_RX_ALIGN = 8;
    localparam int C_RX_UNDER = 9;
    localparam int C_RX_FRAG  = 10;
    localparam int C_RX_OVER  = 11;
    localparam int C_RX_JAB   = 12;
    localparam int C_RX_DROP  = 13;
    localparam int C_BIN0     = 14;
    localparam int NUM_BINS   = 7;
    localparam int C_TX_GOOD  = 21;
    localparam int C_TX_BYTES = 22;
    localparam int C_TX_UC    = 23;
    localparam int C_TX_MC    = 24;
    localparam int C_TX_BC    = 25;
    localparam int C_TX_VLAN  = 26;
    localparam int C_TX_PAUSE = 27;
    localparam int C_COL1     = 28;
    localparam int C_COL_MANY = 29;
    localparam int C_COL_LATE = 30;
    localparam int C_COL_XS   = 31;
    localparam int C_TX_DEFER = 32;
    localparam int C_TX_CRS   = 33;

    localparam int MIN_LEN = 64;

    typedef enum logic [1:0] {
        CLS_UC   = 2'd0,
        CLS_MC   = 2'd1,
        CLS_BC   = 2'd2,
        CLS_NONE = 2'd3
    } cls_e;

    typedef enum logic [2:0] {
        COL_NONE   = 3'd0,
        COL_SINGLE = 3'd1,
        COL_MULTI  = 3'd2,
        COL_LATE   = 3'd3,
        COL_EXCESS = 3'd4
    } col_e;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_LOW  = 2'd1,
        RD_HIGH = 2'd2
    } rd_state_e;

    // upper bound of each histogram bin except the last one
    function automatic int unsigned bin_top(int unsigned b);
        case (b)
            0: return 64;
            1: return 127;
            2: return 255;
            3: return 511;
            4: return 1023;
            default: return 1518;
        endcase
    endfunction

endpackage

// File: rtl/stat_evt_decode.sv
module stat_evt_decode
    import stat_pkg::*;
#(
    parameter int LEN_W   = 14,
    parameter int MAX_LEN = 2000
) (
    input  logic               rx_vld,
    input  logic [LEN_W-1:0]   rx_len,
    input  logic               rx_fcs_err,
    input  logic               rx_align_err,
    input  logic [1:0]         rx_cls,
    input  logic               rx_vlan,
    input  logic               rx_pause,
    input  logic               rx_drop,
    input  logic               tx_vld,
    input  logic               tx_ok,
    input  logic [1:0]         tx_cls,
    input  logic               tx_vlan,
    input  logic               tx_pause,
    input  logic [2:0]         tx_col,
    input  logic               tx_defer,
    input  logic               tx_crs_err,
    output logic [NUM_CNT-1:0] hit
);

    logic rx_err, rx_short, rx_long, rx_good, tx_good;
    logic [NUM_BINS-1:0] bin_hit;

    assign rx_err   = rx_fcs_err | rx_align_err;
    assign rx_short = 32'(rx_len) < MIN_LEN;
    assign rx_long  = 32'(rx_len) > MAX_LEN;
    assign rx_good  = rx_vld & ~rx_err & ~rx_short & ~rx_long;
    assign tx_good  = tx_vld & tx_ok;

    // one-hot size bin: a bin fires when the length is above the previous
    // bound and at or below its own
    genvar b;
    generate
        for (b = 0; b < NUM_BINS; b++) begin : g_bin
            logic above_lo, below_hi;
            if (b == 0) begin : g_first
                assign above_lo = 1'b1;
            end else begin : g_rest
                assign above_lo = 32'(rx_len) > bin_top(b - 1);
            end
            if (b == NUM_BINS - 1) begin : g_last
                assign below_hi = ~rx_long;
            end else begin : g_mid
                assign below_hi = 32'(rx_len) <= bin_top(b);
            end
            assign bin_hit[b] = rx_vld & above_lo & below_hi;
        end
    endgenerate

    always_comb begin
        hit = '0;
        hit[C_RX_GOOD]  = rx_good;
        hit[C_RX_BYTES] = rx_good;
        hit[C_RX_UC]    = rx_good & (cls_e'(rx_cls) == CLS_UC);
        hit[C_RX_MC]    = rx_good & (cls_e'(rx_cls) == CLS_MC);
        hit[C_RX_BC]    = rx_good & (cls_e'(rx_cls) == CLS_BC);
        hit[C_RX_VLAN]  = rx_good & rx_vlan;
        hit[C_RX_PAUSE] = rx_good & rx_pause;
        hit[C_RX_FCS]   = rx_vld & rx_fcs_err;
        hit[C_RX_ALIGN] = rx_vld & rx_align_err;
        hit[C_RX_UNDER] = rx_vld & rx_short & ~rx_err;
        hit[C_RX_FRAG]  = rx_vld & rx_short & rx_err;
        hit[C_RX_OVER]  = rx_vld & rx_long & ~rx_err;
        hit[C_RX_JAB]   = rx_vld & rx_long & rx_err;
        hit[C_RX_DROP]  = rx_vld & rx_drop;
        hit[C_BIN0 +: NUM_BINS] = bin_hit;
        hit[C_TX_GOOD]  = tx_good;
        hit[C_TX_BYTES] = tx_good;
        hit[C_TX_UC]    = tx_good & (cls_e'(tx_cls) == CLS_UC);
        hit[C_TX_MC]    = tx_good & (cls_e'(tx_cls) == CLS_MC);
        hit[C_TX_BC]    = tx_good & (cls_e'(tx_cls) == CLS_BC);
        hit[C_TX_VLAN]  = tx_good & tx_vlan;
        hit[C_TX_PAUSE] = tx_good & tx_pause;
        hit[C_COL1]     = tx_vld & (col_e'(tx_col) == COL_SINGLE);
        hit[C_COL_MANY] = tx_vld & (col_e'(tx_col) == COL_MULTI);
        hit[C_COL_LATE] = tx_vld & (col_e'(tx_col) == COL_LATE);
        hit[C_COL_XS]   = tx_vld & (col_e'(tx_col) == COL_EXCESS);
        hit[C_TX_DEFER] = tx_vld & tx_defer;
        hit[C_TX_CRS]   = tx_vld & tx_crs_err;
    end

endmodule

// File: rtl/stat_ctr_array.sv
module stat_ctr_array
    import stat_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int LEN_W = 14
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_CNT-1:0]         hit,
    input  logic [LEN_W-1:0]           rx_len,
    input  logic [LEN_W-1:0]           tx_len,
    output logic [NUM_CNT*CNT_W-1:0]   cnt_flat
);

    genvar i;
    generate
        for (i = 0; i < NUM_CNT; i++) begin : g_cnt
            logic [CNT_W-1:0] q;
            logic [CNT_W-1:0] step;
            if (i == C_RX_BYTES) begin : g_rxb
                assign step = CNT_W'(rx_len);
            end else if (i == C_TX_BYTES) begin : g_txb
                assign step = CNT_W'(tx_len);
            end else begin : g_one
                assign step = CNT_W'(1);
            end
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (hit[i]) begin
                    q <= q + step;
                end
            end
            assign cnt_flat[i*CNT_W +: CNT_W] = q;
        end
    endgenerate

endmodule

// File: rtl/stat_rd_fsm.sv
module stat_rd_fsm
    import stat_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int DATA_W    = 32,
    parameter int PORT_W    = 2,
    parameter int ADDR_W    = 9,
    localparam int CNT_W    = 2 * DATA_W,
    localparam int TOT_W    = NUM_PORTS * NUM_CNT * CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TOT_W-1:0]  cnt_all,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    rd_state_e         state, state_nx;
    logic              hi_sel;
    logic [PORT_W-1:0] port_f;
    logic [IDX_W-1:0]  idx_f;
    logic              mapped;
    logic [CNT_W-1:0]  sel_cnt;
    logic [DATA_W-1:0] hi_q;
    logic [DATA_W-1:0] data_q;

    assign hi_sel = rd_addr[ADDR_W-1];
    assign port_f = rd_addr[IDX_W +: PORT_W];
    assign idx_f  = rd_addr[IDX_W-1:0];
    assign mapped = (32'(port_f) < NUM_PORTS) && (32'(idx_f) < NUM_CNT);

    always_comb begin
        sel_cnt = '0;
        if (mapped) begin
            sel_cnt = cnt_all[(32'(port_f) * NUM_CNT + 32'(idx_f)) * CNT_W +: CNT_W];
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RD_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state: every state accepts a new request
    always_comb begin
        state_nx = RD_IDLE;
        unique case (state)
            RD_IDLE, RD_LOW, RD_HIGH: begin
                if (rd_en && hi_sel) begin
                    state_nx = RD_HIGH;
                end else if (rd_en) begin
                    state_nx = RD_LOW;
                end else begin
                    state_nx = RD_IDLE;
                end
            end
            default: state_nx = RD_IDLE;
        endcase
    end

    // response word and shared upper-half capture
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            hi_q   <= '0;
        end else if (rd_en) begin
            if (hi_sel) begin
                data_q <= hi_q;
            end else begin
                data_q <= sel_cnt[DATA_W-1:0];
                hi_q   <= sel_cnt[CNT_W-1:DATA_W];
            end
        end
    end

    // outputs
    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        unique case (state)
            RD_IDLE: begin
                rd_valid = 1'b0;
            end
            RD_LOW, RD_HIGH: begin
                rd_valid = 1'b1;
                rd_data  = data_q;
            end
            default: rd_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/stat_bank.sv
module stat_bank
    import stat_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 14,
    parameter int MAX_LEN   = 2000,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int ADDR_W   = 1 + PORT_W + IDX_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_PORTS-1:0]       rx_vld,
    input  logic [NUM_PORTS*LEN_W-1:0] rx_len,
    input  logic [NUM_PORTS-1:0]       rx_fcs_err,
    input  logic [NUM_PORTS-1:0]       rx_align_err,
    input  logic [NUM_PORTS*2-1:0]     rx_cls,
    input  logic [NUM_PORTS-1:0]       rx_vlan,
    input  logic [NUM_PORTS-1:0]       rx_pause,
    input  logic [NUM_PORTS-1:0]       rx_drop,
    input  logic [NUM_PORTS-1:0]       tx_vld,
    input  logic [NUM_PORTS*LEN_W-1:0] tx_len,
    input  logic [NUM_PORTS-1:0]       tx_ok,
    input  logic [NUM_PORTS*2-1:0]     tx_cls,
    input  logic [NUM_PORTS-1:0]       tx_vlan,
    input  logic [NUM_PORTS-1:0]       tx_pause,
    input  logic [NUM_PORTS*3-1:0]     tx_col,
    input  logic [NUM_PORTS-1:0]       tx_defer,
    input  logic [NUM_PORTS-1:0]       tx_crs_err,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic                     rd_valid,
    output logic [DATA_W-1:0]        rd_data
);

    localparam int CNT_W  = 2 * DATA_W;
    localparam int BANK_W = NUM_CNT * CNT_W;

    logic [NUM_PORTS*BANK_W-1:0] cnt_all;

    genvar p;
    generate
        for (p = 0; p < NUM_PORTS; p++) begin : g_port
            logic [NUM_CNT-1:0] hit;

            stat_evt_decode #(
                .LEN_W   (LEN_W),
                .MAX_LEN (MAX_LEN)
            ) u_dec (
                .rx_vld       (rx_vld[p]),
                .rx_len       (rx_len[p*LEN_W +: LEN_W]),
                .rx_fcs_err   (rx_fcs_err[p]),
                .rx_align_err (rx_align_err[p]),
                .rx_cls       (rx_cls[p*2 +: 2]),
                .rx_vlan      (rx_vlan[p]),
                .rx_pause     (rx_pause[p]),
                .rx_drop      (rx_drop[p]),
                .tx_vld       (tx_vld[p]),
                .tx_ok        (tx_ok[p]),
                .tx_cls       (tx_cls[p*2 +: 2]),
                .tx_vlan      (tx_vlan[p]),
                .tx_pause     (tx_pause[p]),
                .tx_col       (tx_col[p*3 +: 3]),
                .tx_defer     (tx_defer[p]),
                .tx_crs_err   (tx_crs_err[p]),
                .hit          (hit)
            );

            stat_ctr_array #(
                .CNT_W (CNT_W),
                .LEN_W (LEN_W)
            ) u_ctr (
                .clk      (clk),
                .rst      (rst),
                .hit      (hit),
                .rx_len   (rx_len[p*LEN_W +: LEN_W]),
                .tx_len   (tx_len[p*LEN_W +: LEN_W]),
                .cnt_flat (cnt_all[p*BANK_W +: BANK_W])
            );
        end
    endgenerate

    stat_rd_fsm #(
        .NUM_PORTS (NUM_PORTS),
        .DATA_W    (DATA_W),
        .PORT_W    (PORT_W),
        .ADDR_W    (ADDR_W)
    ) u_rd (
        .clk      (clk),
        .rst      (rst),
        .cnt_all  (cnt_all),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk
    import stat_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int DATA_W    = 32,
    parameter int PORT_W    = 2,
    parameter int ADDR_W    = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data
);

    logic hi_req, unmapped_req;
    assign hi_req = rd_en && rd_addr[ADDR_W-1];
    assign unmapped_req = rd_en && !rd_addr[ADDR_W-1] &&
        ((32'(rd_addr[IDX_W-1:0]) >= NUM_CNT) ||
         (32'(rd_addr[IDX_W +: PORT_W]) >= NUM_PORTS));

    p_valid_after_req_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    p_idle_without_req_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (rst)
        unmapped_req |=> (rd_data == '0));

    p_hi_repeat_r3: assert property (@(posedge clk) disable iff (rst)
        (hi_req && $past(hi_req)) |=> (rd_data == $past(rd_data)));

endmodule

bind stat_bank stat_bank_chk #(
    .NUM_PORTS (NUM_PORTS),
    .DATA_W    (DATA_W),
    .PORT_W    (PORT_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
);

// File: tb/sim_stat_bank.sv
module sim_stat_bank;

    localparam int NP      = 4;
    localparam int DW      = 16;
    localparam int LW      = 14;
    localparam int MAXL    = 2000;
    localparam int AW      = 9;
    localparam int NC      = 34;
    localparam longint MASK = 64'hFFFF_FFFF;

    logic clk = 0;
    logic rst = 1;
    always #2.5 clk = ~clk;

    logic [NP-1:0]    rx_vld = '0, rx_fcs_err = '0, rx_align_err = '0;
    logic [NP-1:0]    rx_vlan = '0, rx_pause = '0, rx_drop = '0;
    logic [NP*LW-1:0] rx_len = '0, tx_len = '0;
    logic [NP*2-1:0]  rx_cls = '0, tx_cls = '0;
    logic [NP-1:0]    tx_vld = '0, tx_ok = '0, tx_vlan = '0, tx_pause = '0;
    logic [NP-1:0]    tx_defer = '0, tx_crs_err = '0;
    logic [NP*3-1:0]  tx_col = '0;
    logic             rd_en = 0;
    logic [AW-1:0]    rd_addr = '0;
    logic             rd_valid;
    logic [DW-1:0]    rd_data;

    stat_bank #(.NUM_PORTS(NP), .DATA_W(DW), .LEN_W(LW), .MAX_LEN(MAXL)) u0 (
        .clk(clk), .rst(rst),
        .rx_vld(rx_vld), .rx_len(rx_len), .rx_fcs_err(rx_fcs_err),
        .rx_align_err(rx_align_err), .rx_cls(rx_cls), .rx_vlan(rx_vlan),
        .rx_pause(rx_pause), .rx_drop(rx_drop),
        .tx_vld(tx_vld), .tx_len(tx_len), .tx_ok(tx_ok), .tx_cls(tx_cls),
        .tx_vlan(tx_vlan), .tx_pause(tx_pause), .tx_col(tx_col),
        .tx_defer(tx_defer), .tx_crs_err(tx_crs_err),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int checks = 0;
    int errors = 0;
    string phase = "R1 reset";

    // reference model
    longint cnt [NP][NC];
    longint hi_m = 0;
    bit     exp_v = 0;
    longint exp_d = 0;
    string  exp_tag = "";

    function automatic string tag_of(int idx, bit hi);
        if (hi) return "R3";
        if (idx <= 6) return "R5";
        if (idx == 13) return "R10";
        if (idx <= 12) return "R6";
        if (idx <= 20) return "R7";
        if (idx <= 27) return "R8";
        if (idx <= 33) return "R9";
        return "R12";
    endfunction

    function automatic int size_bin(int len);
        if (len <= 64) return 0;
        if (len <= 127) return 1;
        if (len <= 255) return 2;
        if (len <= 511) return 3;
        if (len <= 1023) return 4;
        if (len <= 1518) return 5;
        return 6;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            foreach (cnt[p, i]) cnt[p][i] = 0;
            hi_m = 0; exp_v = 0; exp_d = 0;
        end else begin
            exp_v = rd_en;
            if (rd_en) begin
                int p, idx; bit hs; longint v;
                hs = rd_addr[8]; p = int'(rd_addr[7:6]); idx = int'(rd_addr[5:0]);
                exp_tag = tag_of(idx, hs);
                if (hs) exp_d = hi_m;
                else begin
                    v = (idx < NC) ? cnt[p][idx] : 0;
                    exp_d = v & 64'hFFFF;
                    hi_m = (v >> 16) & 64'hFFFF;
                end
            end
            for (int p = 0; p < NP; p++) begin
                if (rx_vld[p]) begin
                    int len; bit e; int c;
                    len = int'(rx_len[p*LW +: LW]);
                    e = rx_fcs_err[p] | rx_align_err[p];
                    c = int'(rx_cls[p*2 +: 2]);
                    if (len < 64) cnt[p][e ? 10 : 9]++;
                    else if (len > MAXL) cnt[p][e ? 12 : 11]++;
                    else if (!e) begin
                        cnt[p][0]++; cnt[p][1] += len;
                        if (c < 3) cnt[p][2 + c]++;
                        if (rx_vlan[p]) cnt[p][5]++;
                        if (rx_pause[p]) cnt[p][6]++;
                    end
                    if (rx_fcs_err[p]) cnt[p][7]++;
                    if (rx_align_err[p]) cnt[p][8]++;
                    if (rx_drop[p]) cnt[p][13]++;
                    if (len <= MAXL) cnt[p][14 + size_bin(len)]++;
                end
                if (tx_vld[p]) begin
                    int len; int c; int k;
                    len = int'(tx_len[p*LW +: LW]);
                    c = int'(tx_cls[p*2 +: 2]);
                    k = int'(tx_col[p*3 +: 3]);
                    if (tx_ok[p]) begin
                        cnt[p][21]++; cnt[p][22] += len;
                        if (c < 3) cnt[p][23 + c]++;
                        if (tx_vlan[p]) cnt[p][26]++;
                        if (tx_pause[p]) cnt[p][27]++;
                    end
                    if (k >= 1 && k <= 4) cnt[p][27 + k]++;
                    if (tx_defer[p]) cnt[p][32]++;
                    if (tx_crs_err[p]) cnt[p][33]++;
                end
                for (int i = 0; i < NC; i++) cnt[p][i] &= MASK;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (rd_valid !== exp_v) begin
                errors++;
                $display("FAIL R2 [%s] rd_valid actual=%0b expected=%0b", phase, rd_valid, exp_v);
            end else if (exp_v) begin
                checks++;
                if (rd_data !== DW'(exp_d)) begin
                    errors++;
                    $display("FAIL %s [%s] rd_data actual=%0h expected=%0h",
                             exp_tag, phase, rd_data, exp_d);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        rx_vld = '0; tx_vld = '0; rd_en = 0;
    endtask

    task automatic rx_ev(int p, int len, bit fcs, bit al, int c, bit vl, bit pa, bit dr);
        rx_vld[p] = 1; rx_len[p*LW +: LW] = LW'(len);
        rx_fcs_err[p] = fcs; rx_align_err[p] = al; rx_cls[p*2 +: 2] = 2'(c);
        rx_vlan[p] = vl; rx_pause[p] = pa; rx_drop[p] = dr;
    endtask

    task automatic tx_ev(int p, int len, bit ok, int c, bit vl, bit pa, int col, bit df, bit cr);
        tx_vld[p] = 1; tx_len[p*LW +: LW] = LW'(len); tx_ok[p] = ok;
        tx_cls[p*2 +: 2] = 2'(c); tx_vlan[p] = vl; tx_pause[p] = pa;
        tx_col[p*3 +: 3] = 3'(col); tx_defer[p] = df; tx_crs_err[p] = cr;
    endtask

    task automatic rd_req(bit hs, int p, int idx);
        rd_en = 1; rd_addr = {hs, 2'(p), 6'(idx)};
    endtask

    task automatic read_port(int p);
        for (int i = 0; i < NC; i++) begin
            rd_req(0, p, i); tick();
            rd_req(1, 0, 0); tick();
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++; checks++;
                $display("FAIL watchdog: run did not complete");
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: everything reads zero after reset
        phase = "R1 reset";
        read_port(0);
        rd_req(0, 3, 33); tick();
        rd_req(1, 0, 0); tick();

        // R5, R7: good frames with varied lengths and classes on port 0
        phase = "R5 R7 good rx";
        rx_ev(0, 64, 0, 0, 0, 0, 0, 0); tick();
        rx_ev(0, 65, 0, 0, 1, 1, 0, 0); tick();
        rx_ev(0, 127, 0, 0, 2, 0, 1, 0); tick();
        rx_ev(0, 128, 0, 0, 3, 0, 0, 0); tick();
        rx_ev(0, 511, 0, 0, 0, 1, 0, 0); tick();
        rx_ev(0, 512, 0, 0, 1, 0, 0, 0); tick();
        rx_ev(0, 1518, 0, 0, 2, 0, 0, 0); tick();
        rx_ev(0, 1519, 0, 0, 0, 0, 0, 0); tick();
        rx_ev(0, MAXL, 0, 0, 0, 0, 0, 0); tick();

        // R6, R10: errors and out-of-range lengths
        phase = "R6 R10 errored rx";
        rx_ev(0, 40, 0, 0, 0, 1, 1, 0); tick();
        rx_ev(0, 63, 1, 0, 0, 0, 0, 0); tick();
        rx_ev(0, MAXL + 1, 0, 0, 1, 0, 0, 1); tick();
        rx_ev(0, 3000, 0, 1, 2, 0, 0, 0); tick();
        rx_ev(0, 300, 1, 1, 0, 1, 0, 1); tick();
        rx_ev(0, 700, 0, 0, 0, 0, 0, 1); tick();

        // R8, R9: transmit outcomes
        phase = "R8 R9 tx";
        tx_ev(0, 100, 1, 0, 1, 0, 0, 0, 0); tick();
        tx_ev(0, 200, 1, 1, 0, 1, 1, 0, 0); tick();
        tx_ev(0, 300, 1, 2, 0, 0, 2, 1, 0); tick();
        tx_ev(0, 400, 0, 0, 1, 1, 3, 0, 1); tick();
        tx_ev(0, 500, 0, 1, 0, 0, 4, 1, 1); tick();
        tx_ev(0, 600, 1, 3, 0, 0, 5, 0, 0); tick();
        read_port(0);

        // R11: port 2 traffic leaves ports 1 and 3 untouched
        phase = "R11 port isolation";
        rx_ev(2, 90, 0, 0, 1, 0, 0, 0); tx_ev(2, 80, 1, 2, 0, 0, 1, 1, 0); tick();
        read_port(2);
        read_port(1);
        read_port(3);

        // R3: capture of the upper half survives a later carry
        phase = "R3 carry";
        for (int k = 0; k < 40; k++) begin rx_ev(1, 1500, 0, 0, 0, 0, 0, 0); tick(); end
        rd_req(0, 1, 1); tick();
        for (int k = 0; k < 10; k++) begin rx_ev(1, 1500, 0, 0, 0, 0, 0, 0); tick(); end
        rd_req(1, 0, 0); tick();
        rd_req(1, 0, 0); tick();
        rd_req(0, 1, 1); tick();
        rd_req(1, 0, 0); tick();

        // R4: read and increment in the same cycle
        phase = "R4 same-cycle";
        rx_ev(1, 1500, 0, 0, 0, 0, 0, 0); rd_req(0, 1, 1); tick();
        rd_req(1, 0, 0); tick();
        rd_req(0, 1, 1); tick();
        rd_req(1, 0, 0); tick();
        tx_ev(1, 77, 1, 0, 0, 0, 0, 0, 0); rd_req(0, 1, 21); tick();

        // R12: unmapped indices read zero and clear the captured half
        phase = "R12 unmapped";
        rd_req(0, 1, 1); tick();
        rd_req(0, 1, 40); tick();
        rd_req(1, 0, 0); tick();
        rd_req(0, 0, 63); tick();

        // R1: reset in the middle clears counters again
        phase = "R1 second reset";
        rst = 1; tick(); tick(); rst = 0;
        read_port(0);
        rd_req(0, 1, 1); tick();
        rd_req(1, 0, 0); tick();

        tick(); tick();
        finish_run();
    end

endmodule